// File: doc/BRIEF.md
# Sync Hunt and Character Assembler

This block is the front end of a character-oriented synchronous receiver. While enabled it first hunts for a programmed sync pattern. Each qualified serial bit slides into a comparison window, and the window is tested against the pattern on every bit. One mode uses a single 8-bit sync character. The other mode uses a 16-bit pair of characters. Serial data arrives least significant bit first.

Once the pattern is found, the hunt phase ends and a one-clock status pulse is raised. Every bit from then on is grouped into characters of a selectable length, from five to eight bits. Each character leaves the block as a full 8-bit word on a FIFO write port. Its first bit sits in bit 0. When the length is below eight, the upper bits of the word are the first bits of the following character.

Options let the block discard characters that equal the second sync character. A full FIFO causes a character to be dropped and raises a sticky overrun flag. A command returns the receiver to the hunt phase at any time.

Top module: `sync_rx_front`

## Requirements
- R1: After reset `in_hunt` is 1, and `fifo_wr`, `sync_found` and `overrun` are 0.
- R2: In single mode (`mode_bisync`=0), the hunt ends on a bit after which the last 8 received bits equal `sync2`, with the earliest of them in bit 0. The bits must have been received since the hunt phase was last entered. `sync1` is not used in this mode.
- R3: In pair mode (`mode_bisync`=1), the hunt ends when the last 16 received bits equal `sync1` followed by `sync2`. `sync1` is received first, and each character is sent least significant bit first. All 16 bits must have been received since hunt entry.
- R4: `sync_found` is high for exactly one clock, in the cycle after the clock edge that accepted the matching bit. `in_hunt` is 0 from that same cycle.
- R5: `char_len_sel` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits per character. The first character starts with the bit that follows the sync pattern, and each later character starts right after the previous one.
- R6: Bit i of the word for a character is the (i+1)-th bit received from that character's first bit. The word is written one clock after the edge that accepts its 8th bit. For lengths under 8, the upper bits are therefore the first bits of the next character.
- R7: A new `char_len_sel` value applied before the last bit of the current character sets where that character ends.
- R8: When `sync_inhibit` is 1, a character whose low L bits equal the low L bits of `sync2` is not written. L is the length of that character.
- R9: If `fifo_full` is 1 when a word is due, the word is not written and `overrun` becomes 1. `overrun` stays 1 until a clock with `ovr_clr`=1.
- R10: `hunt_cmd` returns the block to the hunt phase from any state. It discards a partly assembled character or a word still waiting for bits. It also empties the hunt window, so bits received earlier cannot complete a match.
- R11: While `rx_enable` is 0, serial bits are ignored, the block stays in the hunt phase, and it neither writes nor reports sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable |
| bit_en | input | 1 | Qualifies `rx_bit` for one clock |
| rx_bit | input | 1 | Serial data bit |
| mode_bisync | input | 1 | 0: single 8-bit sync, 1: 16-bit sync pair |
| sync1 | input | 8 | First sync character (pair mode) |
| sync2 | input | 8 | Second sync character, used in both modes |
| char_len_sel | input | 2 | Character length code, length = 5 + code |
| sync_inhibit | input | 1 | Discard characters equal to `sync2` |
| hunt_cmd | input | 1 | Force hunt phase |
| ovr_clr | input | 1 | Clear overrun flag |
| fifo_full | input | 1 | Receive FIFO cannot accept a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| sync_found | output | 1 | One-clock pulse when the hunt ends |
| in_hunt | output | 1 | Receiver is in the hunt phase |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Some properties are checked on every cycle:
- the found pulse lasts one clock and coincides with the phase change;
- the hunt command and a disabled receiver always leave the block in the hunt phase and quiet;
- no word is written against a full FIFO or out of the hunt phase, and an inhibited pattern never reaches the FIFO;
- the overrun flag holds until it is cleared.

Other behaviour can only be shown by the bench's scenarios:
- where the match lands in the bit stream;
- how the characters are aligned and how leftover upper bits carry over from the next character;
- the effect of a length change in the middle of a character;
- the discarding of a waiting word by the hunt command.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  typedef enum logic {
    PH_HUNT = 1'b0,
    PH_DATA = 1'b1
  } rx_phase_e;

  // Number of bits per character for a length code.
  function automatic logic [3:0] len_of(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // Mask of the character bits inside an 8-bit word.
  function automatic logic [7:0] len_mask(input logic [1:0] code);
    return 8'hFF >> (2'd3 - code);
  endfunction

endpackage

// File: rtl/sync_hunt_cmp.sv
module sync_hunt_cmp #(
  parameter int SYNC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              clear,
  input  logic              rx_bit,
  input  logic              pair_mode,
  input  logic [SYNC_W-1:0] sync_a,
  input  logic [SYNC_W-1:0] sync_b,
  output logic              hit
);

  localparam int WIN_W  = 2 * SYNC_W;
  localparam int FILL_W = $clog2(WIN_W + 1);

  logic [WIN_W-1:0]  win_q, win_d, win_n;
  logic [FILL_W-1:0] fill_q, fill_n;
  logic              single_hit, pair_hit;

  // Newest bit enters at the top; the earliest bit ends up lowest.
  assign win_d = {rx_bit, win_q[WIN_W-1:1]};

  assign single_hit = (fill_q >= FILL_W'(SYNC_W - 1)) &&
                      (win_d[WIN_W-1:SYNC_W] == sync_b);
  assign pair_hit   = (fill_q >= FILL_W'(WIN_W - 1)) &&
                      (win_d == {sync_b, sync_a});

  assign hit = shift_en && !clear && (pair_mode ? pair_hit : single_hit);

  always_comb begin
    win_n  = win_q;
    fill_n = fill_q;
    if (clear) begin
      win_n  = '0;
      fill_n = '0;
    end else if (shift_en) begin
      win_n = win_d;
      if (fill_q != FILL_W'(WIN_W)) begin
        fill_n = fill_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_n;
      fill_q <= fill_n;
    end
  end

  // R10
  window_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill_q == '0) && !hit);

endmodule

// File: rtl/char_assembler.sv
module char_assembler
  import sync_rx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              clear,
  input  logic              rx_bit,
  input  logic [1:0]        len_code,
  output logic              emit,
  output logic [CHAR_W-1:0] word,
  output logic [1:0]        word_len
);

  localparam int CNT_W = $clog2(CHAR_W);

  logic [CHAR_W-1:0] sr_q, sr_n, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              pend_q, pend_n;
  logic [1:0]        prem_q, prem_n;
  logic [1:0]        plen_q, plen_n;
  logic [3:0]        len_now;
  logic              last_bit, pend_done, full_len;

  assign sr_d      = {rx_bit, sr_q[CHAR_W-1:1]};
  assign len_now   = len_of(len_code);
  // A length shortened below the bits already taken ends the character now.
  assign last_bit  = (4'(cnt_q) >= (len_now - 4'd1));
  assign full_len  = (len_code == 2'd3);
  assign pend_done = pend_q && (prem_q == 2'd1);

  assign emit     = shift_en && !clear && (pend_done || (last_bit && full_len));
  assign word     = sr_d;
  assign word_len = pend_q ? plen_q : len_code;

  always_comb begin
    sr_n   = sr_q;
    cnt_n  = cnt_q;
    pend_n = pend_q;
    prem_n = prem_q;
    plen_n = plen_q;
    if (clear) begin
      cnt_n  = '0;
      pend_n = 1'b0;
      prem_n = '0;
    end else if (shift_en) begin
      sr_n = sr_d;
      if (pend_q) begin
        prem_n = prem_q - 1'b1;
        if (pend_done) begin
          pend_n = 1'b0;
        end
      end
      if (last_bit) begin
        cnt_n = '0;
        if (!full_len) begin
          // Word waits for the first bits of the next character.
          pend_n = 1'b1;
          prem_n = 2'(4'd8 - len_now);
          plen_n = len_code;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      prem_q <= '0;
      plen_q <= '0;
    end else begin
      sr_q   <= sr_n;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      prem_q <= prem_n;
      plen_q <= plen_n;
    end
  end

  // R6
  pend_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (prem_q != 2'd0));

  // R10
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pend_q && (cnt_q == '0));

endmodule

// File: rtl/fifo_writer.sv
module fifo_writer
  import sync_rx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              emit,
  input  logic [CHAR_W-1:0] word,
  input  logic [1:0]        word_len,
  input  logic [CHAR_W-1:0] match_pat,
  input  logic              inhibit,
  input  logic              fifo_full,
  input  logic              ovr_clr,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wdata,
  output logic              overrun
);

  logic              wr_q, wr_n;
  logic [CHAR_W-1:0] data_q, data_n;
  logic              ovr_q, ovr_n;
  logic              drop_sync, want;

  assign drop_sync = inhibit && (((word ^ match_pat) & len_mask(word_len)) == '0);
  assign want      = emit && !flush && !drop_sync;

  always_comb begin
    wr_n   = want && !fifo_full;
    data_n = want ? word : data_q;
    // A new overrun event wins over a clear in the same clock.
    ovr_n  = (ovr_q && !ovr_clr) || (want && fifo_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      data_q <= data_n;
      ovr_q  <= ovr_n;
    end
  end

  assign fifo_wr    = wr_q;
  assign fifo_wdata = data_q;
  assign overrun    = ovr_q;

  // R9
  wr_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !$past(fifo_full));

  // R9
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && $past(inhibit)) |->
      (((fifo_wdata ^ $past(match_pat)) & len_mask($past(word_len))) != '0));

endmodule

// File: rtl/sync_rx_front.sv
module sync_rx_front
  import sync_rx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              mode_bisync,
  input  logic [CHAR_W-1:0] sync1,
  input  logic [CHAR_W-1:0] sync2,
  input  logic [1:0]        char_len_sel,
  input  logic              sync_inhibit,
  input  logic              hunt_cmd,
  input  logic              ovr_clr,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wdata,
  output logic              sync_found,
  output logic              in_hunt,
  output logic              overrun
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  rx_phase_e         phase_q, phase_n;
  logic              found_q, found_n;
  logic              clear_all, hunt_shift, data_shift, hit;
  logic              emit;
  logic [CHAR_W-1:0] word;
  logic [1:0]        word_len;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  assign clear_all  = hunt_cmd || !rx_enable;
  assign hunt_shift = bit_en && !clear_all && (phase_q == PH_HUNT);
  assign data_shift = bit_en && !clear_all && (phase_q == PH_DATA);

  sync_hunt_cmp #(.SYNC_W(CHAR_W)) i_hunt (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .shift_en  (hunt_shift),
    .clear     (clear_all),
    .rx_bit    (rx_bit),
    .pair_mode (mode_bisync),
    .sync_a    (sync1),
    .sync_b    (sync2),
    .hit       (hit)
  );

  char_assembler #(.CHAR_W(CHAR_W)) i_asm (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .shift_en (data_shift),
    .clear    (clear_all || hit),
    .rx_bit   (rx_bit),
    .len_code (char_len_sel),
    .emit     (emit),
    .word     (word),
    .word_len (word_len)
  );

  fifo_writer #(.CHAR_W(CHAR_W)) i_wr (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .flush      (clear_all),
    .emit       (emit),
    .word       (word),
    .word_len   (word_len),
    .match_pat  (sync2),
    .inhibit    (sync_inhibit),
    .fifo_full  (fifo_full),
    .ovr_clr    (ovr_clr),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .overrun    (overrun)
  );

  always_comb begin
    phase_n = phase_q;
    if (clear_all) begin
      phase_n = PH_HUNT;
    end else if (hit) begin
      phase_n = PH_DATA;
    end
    found_n = hit;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= PH_HUNT;
      found_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      found_q <= found_n;
    end
  end

  assign in_hunt    = (phase_q == PH_HUNT);
  assign sync_found = found_q;

  // R4
  found_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    sync_found |=> !sync_found);

  // R4
  found_phase_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    sync_found |-> !in_hunt && $past(in_hunt));

  // R10
  cmd_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    hunt_cmd |=> in_hunt && !sync_found && !fifo_wr);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rx_enable |=> in_hunt && !sync_found && !fifo_wr);

  // R5
  wr_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    fifo_wr |-> !$past(in_hunt));

endmodule

// File: tb/test_sync_rx_front.sv
module test_sync_rx_front;

  localparam logic [7:0] SYNC1 = 8'h32;
  localparam logic [7:0] SYNC2 = 8'h16;
  localparam int NVEC = 7;

  // {mode_bisync, len code, inhibit, 32 data bits sent LSB first}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 2'd3, 1'b0, 32'hC3A55A0F},
    {1'b1, 2'd3, 1'b0, 32'h12345678},
    {1'b0, 2'd0, 1'b0, 32'hDEADBEEF},
    {1'b1, 2'd1, 1'b0, 32'h0F0F3C3C},
    {1'b0, 2'd2, 1'b0, 32'h80017FFE},
    {1'b0, 2'd3, 1'b1, 32'h16421641},
    {1'b1, 2'd0, 1'b1, 32'hA5A5A5B6}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_enable, bit_en, rx_bit, mode_bisync;
  logic [1:0] char_len_sel;
  logic       sync_inhibit, hunt_cmd, ovr_clr, fifo_full;
  logic       fifo_wr, sync_found, in_hunt, overrun;
  logic [7:0] fifo_wdata;

  int n_checks = 0;
  int n_fail = 0;
  int cap_n = 0;
  int exp_n = 0;
  logic [7:0] cap [16];
  logic [7:0] exp_w [16];
  bit done = 0;

  always #5 clk = ~clk;

  sync_rx_front i_sync_rx_front (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_enable    (rx_enable),
    .bit_en       (bit_en),
    .rx_bit       (rx_bit),
    .mode_bisync  (mode_bisync),
    .sync1        (SYNC1),
    .sync2        (SYNC2),
    .char_len_sel (char_len_sel),
    .sync_inhibit (sync_inhibit),
    .hunt_cmd     (hunt_cmd),
    .ovr_clr      (ovr_clr),
    .fifo_full    (fifo_full),
    .fifo_wr      (fifo_wr),
    .fifo_wdata   (fifo_wdata),
    .sync_found   (sync_found),
    .in_hunt      (in_hunt),
    .overrun      (overrun)
  );

  always @(negedge clk) begin
    if (fifo_wr && cap_n < 16) begin
      cap[cap_n] = fifo_wdata;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic pulse_hunt();
    @(negedge clk);
    hunt_cmd = 1'b1;
    @(negedge clk);
    hunt_cmd = 1'b0;
  endtask

  task automatic sync_up(input logic pair);
    pulse_hunt();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    if (pair) send_byte(SYNC1);
    send_byte(SYNC2);
  endtask

  // Expected words: each character starts L bits after the previous one,
  // the word is the 8 bits from its start, skipped when inhibited.
  task automatic build_expect(input logic [31:0] d, input int len, input logic inh);
    logic [7:0] w;
    logic [7:0] m;
    exp_n = 0;
    m = 8'hFF >> (8 - len);
    for (int s = 0; s + 7 <= 31; s += len) begin
      w = d[s +: 8];
      if (!(inh && (((w ^ SYNC2) & m) == 8'h00))) begin
        exp_w[exp_n] = w;
        exp_n++;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    rx_enable = 1'b1; bit_en = 1'b0; rx_bit = 1'b0; mode_bisync = 1'b0;
    char_len_sel = 2'd3; sync_inhibit = 1'b0; hunt_cmd = 1'b0;
    ovr_clr = 1'b0; fifo_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 in_hunt", in_hunt, 1);
    chk("R1 fifo_wr", fifo_wr, 0);
    chk("R1 sync_found", sync_found, 0);
    chk("R1 overrun", overrun, 0);

    // Vector table: R2/R3 hunt, R5/R6 assembly, R8 inhibit
    for (int v = 0; v < NVEC; v++) begin
      mode_bisync  = VEC[v][35];
      char_len_sel = VEC[v][34:33];
      sync_inhibit = VEC[v][32];
      sync_up(VEC[v][35]);
      chk(VEC[v][35] ? "R3 sync_found" : "R2 sync_found", sync_found, 1);
      chk("R4 in_hunt low", in_hunt, 0);
      @(negedge clk);
      chk("R4 pulse ends", sync_found, 0);
      cap_n = 0;
      for (int i = 0; i < 32; i++) send_bit(VEC[v][i]);
      @(negedge clk);
      build_expect(VEC[v][31:0], 5 + int'(VEC[v][34:33]), VEC[v][32]);
      chk(VEC[v][32] ? "R8 word count" : "R5 word count", cap_n, exp_n);
      for (int k = 0; k < exp_n && k < cap_n; k++)
        chk(VEC[v][32] ? "R8 word" : "R6 word", cap[k], exp_w[k]);
    end
    sync_inhibit = 1'b0;

    // R2: single mode ignores sync1
    mode_bisync = 1'b0;
    pulse_hunt();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_byte(SYNC1);
    chk("R2 sync1 ignored", sync_found, 0);
    chk("R2 still hunting", in_hunt, 1);

    // R7: length shortened from 8 to 5 during the first character
    begin
      logic [15:0] d;
      d = 16'hB7C9;
      mode_bisync = 1'b0;
      char_len_sel = 2'd3;
      sync_up(1'b0);
      cap_n = 0;
      send_bit(d[0]);
      send_bit(d[1]);
      char_len_sel = 2'd0;
      for (int i = 2; i < 16; i++) send_bit(d[i]);
      @(negedge clk);
      chk("R7 count", cap_n, 2);
      chk("R7 word0", cap[0], d[7:0]);
      chk("R7 word1", cap[1], d[12:5]);
    end

    // R9: overrun on full FIFO, sticky until cleared
    char_len_sel = 2'd3;
    fifo_full = 1'b1;
    sync_up(1'b0);
    cap_n = 0;
    send_byte(8'hA5);
    @(negedge clk);
    chk("R9 dropped", cap_n, 0);
    chk("R9 overrun set", overrun, 1);
    fifo_full = 1'b0;
    send_byte(8'h3C);
    @(negedge clk);
    chk("R9 next write", cap_n, 1);
    chk("R9 next data", cap[0], 8'h3C);
    chk("R9 overrun sticky", overrun, 1);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk("R9 overrun cleared", overrun, 0);

    // R10: hunt command drops a waiting word
    char_len_sel = 2'd0;
    sync_up(1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    pulse_hunt();
    chk("R10 in_hunt", in_hunt, 1);
    cap_n = 0;
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    @(negedge clk);
    chk("R10 word dropped", cap_n, 0);

    // R10: hunt command empties the window
    pulse_hunt();
    send_bit(SYNC2[0]);
    pulse_hunt();
    for (int i = 1; i < 8; i++) send_bit(SYNC2[i]);
    chk("R10 window cleared", sync_found, 0);

    // R11: disabled receiver ignores bits
    rx_enable = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_byte(SYNC2);
    chk("R11 no sync", sync_found, 0);
    chk("R11 in_hunt", in_hunt, 1);
    rx_enable = 1'b1;

    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule